// File: doc/BRIEF.md
# Age-Addressed Operand Belt

This block stores operands in a fixed-length queue of slots. Callers name a value by how many places it sits behind the front, not by a register number. Each cycle, functional units may push up to a few results onto the front. Every older value moves back by the number pushed, and values pushed past the last slot are lost. Because values are written once and never changed in place, the block has no hazard tracking.

A rescue command names a short list of current positions. That list is moved to the front in the order given, and all unnamed slots follow in their previous relative order. When a rescue and new results arrive in the same cycle, the rescue reordering is applied first and the new results are then placed in front of it. Reads are combinational. They see the stored contents as they stand before that cycle's update.

Top module: `belt_store`

## Requirements
- R1: After reset every slot is empty, and every read port returns zero data with its valid flag low.
- R2: In a cycle with no valid drop and no rescue, every slot keeps its data and valid flag.
- R3: With n valid drops and no rescue, the new values occupy positions 0..n-1 and the entry formerly at position p moves to position p+n. All these positions become valid.
- R4: Valid drops are packed by port number. The lowest-numbered valid drop port goes to position 0, the next valid one to position 1, and so on, whatever gaps lie between them.
- R5: An entry whose new position would be LEN or beyond is discarded, and the count of valid slots never falls in a cycle without a rescue.
- R6: A read port given offset k returns the slot at position k combinationally. Within a cycle it shows the contents from before that cycle's drops or rescue.
- R7: Reading an empty slot returns all-zero data with the valid flag low. Reading a filled slot returns its data with the flag high.
- R8: A rescue with count c (clamped to the list length) and c distinct positions places the named entries at positions 0..c-1 in list order. The unnamed slots follow from position c in their former order, with valid flags moving along with the data. Position field j of the list is bits j*AW+AW-1 down to j*AW.
- R9: When a rescue and drops happen in the same cycle, the rescue reordering is applied first and the packed drops are then pushed in front of the result.
- R10: A rescue with count 0 leaves the belt unchanged.
- R11: All read ports are independent. Ports given the same offset return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| drop_vld | input | NDROP | Per-port drop valid, port 0 highest priority |
| drop_data | input | NDROP*DW | Drop values, port i at bits i*DW upward |
| resc_en | input | 1 | Rescue command this cycle |
| resc_cnt | input | CW | Number of list entries used by the rescue |
| resc_pos | input | NRESC*AW | Rescue position list, entry j at bits j*AW upward |
| rd_off | input | NRD*AW | Read offsets from the front, one field per port |
| rd_data | output | NRD*DW | Read data, zero when the slot is empty |
| rd_vld | output | NRD | Read valid flag per port |

## Verification
The bench builds the block with an 8-slot belt, 16-bit data, four drop ports, four read ports and a three-entry rescue list. At that size the bench can read back every position after every step. It drives all sixteen drop-valid patterns repeatedly, so each gap pattern and the overflow past the last slot both occur. Many rescue lists of every legal length are also applied, both alone and together with drops. The expected belt is rebuilt after each step by a queue model in the bench.

// File: rtl/belt_pkg.sv
package belt_pkg;

  // Number of set bits in v below bit index lim.
  function automatic int ones_below(input logic [31:0] v, input int lim);
    int n;
    n = 0;
    for (int i = 0; i < 32; i++) begin
      if (i < lim && v[i]) n++;
    end
    return n;
  endfunction

  // Source position of belt slot j after n drops are pushed in front.
  function automatic int shifted_src(input int j, input int n);
    return j - n;
  endfunction

  // Clamp a requested rescue length to the list capacity.
  function automatic int clamp_len(input int req, input int cap);
    return (req > cap) ? cap : req;
  endfunction

endpackage

// File: rtl/belt_pack.sv
module belt_pack #(
  parameter int NDROP = 4,
  parameter int DW    = 64,
  parameter int DCW   = 3
) (
  input  logic [NDROP-1:0]            vld,
  input  logic [NDROP*DW-1:0]         data,
  output logic [NDROP-1:0][DW-1:0]    packed_q,
  output logic [DCW-1:0]              cnt
);
  // Valid drops are compacted in port order: the lowest valid port goes to slot 0.
  always_comb begin
    int k;
    packed_q = '0;
    k = 0;
    for (int i = 0; i < NDROP; i++) begin
      if (vld[i]) begin
        packed_q[k] = data[i*DW +: DW];
        k++;
      end
    end
    cnt = DCW'(k);
  end
endmodule

// File: rtl/belt_rescue.sv
module belt_rescue #(
  parameter int LEN   = 16,
  parameter int DW    = 64,
  parameter int NRESC = 4,
  parameter int AW    = 4,
  parameter int CW    = 3
) (
  input  logic [LEN-1:0][DW-1:0] cur_data,
  input  logic [LEN-1:0]         cur_vld,
  input  logic                   en,
  input  logic [CW-1:0]          cnt,
  input  logic [NRESC*AW-1:0]    pos,
  output logic [LEN-1:0][DW-1:0] mid_data,
  output logic [LEN-1:0]         mid_vld
);
  import belt_pkg::*;

  logic [LEN-1:0] named;

  always_comb begin
    int c;
    int dst;
    logic [AW-1:0] p;
    named    = '0;
    mid_data = '0;
    mid_vld  = '0;
    c        = clamp_len(int'(cnt), NRESC);
    dst      = 0;
    p        = '0;
    if (!en) begin
      mid_data = cur_data;
      mid_vld  = cur_vld;
    end else begin
      // named operands to the front, in list order
      for (int j = 0; j < NRESC; j++) begin
        if (j < c) begin
          p           = pos[j*AW +: AW];
          named[p]    = 1'b1;
          mid_data[j] = cur_data[p];
          mid_vld[j]  = cur_vld[p];
        end
      end
      // unnamed slots follow in their former order
      dst = c;
      for (int i = 0; i < LEN; i++) begin
        if (!named[i]) begin
          if (dst < LEN) begin
            mid_data[dst] = cur_data[i];
            mid_vld[dst]  = cur_vld[i];
          end
          dst++;
        end
      end
    end
  end
endmodule

// File: rtl/belt_read.sv
module belt_read #(
  parameter int LEN = 16,
  parameter int DW  = 64,
  parameter int NRD = 4,
  parameter int AW  = 4
) (
  input  logic [LEN-1:0][DW-1:0] slot_data,
  input  logic [LEN-1:0]         slot_vld,
  input  logic [NRD*AW-1:0]      off,
  output logic [NRD*DW-1:0]      data,
  output logic [NRD-1:0]         vld
);
  for (genvar r = 0; r < NRD; r++) begin : g_port
    logic [AW-1:0] sel;
    assign sel              = off[r*AW +: AW];
    assign vld[r]           = slot_vld[sel];
    assign data[r*DW +: DW] = slot_vld[sel] ? slot_data[sel] : '0;
  end
endmodule

// File: rtl/belt_store.sv
module belt_store #(
  parameter int LEN   = 16,
  parameter int DW    = 64,
  parameter int NDROP = 4,
  parameter int NRD   = 4,
  parameter int NRESC = 4,
  localparam int AW   = $clog2(LEN),
  localparam int CW   = $clog2(NRESC + 1),
  localparam int DCW  = $clog2(NDROP + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NDROP-1:0]    drop_vld,
  input  logic [NDROP*DW-1:0] drop_data,
  input  logic                resc_en,
  input  logic [CW-1:0]       resc_cnt,
  input  logic [NRESC*AW-1:0] resc_pos,
  input  logic [NRD*AW-1:0]   rd_off,
  output logic [NRD*DW-1:0]   rd_data,
  output logic [NRD-1:0]      rd_vld
);
  import belt_pkg::*;

  logic [LEN-1:0][DW-1:0]   slot_q;
  logic [LEN-1:0]           vld_q;
  logic [NDROP-1:0][DW-1:0] packed_drops;
  logic [DCW-1:0]           drop_cnt;
  logic [LEN-1:0][DW-1:0]   mid_data;
  logic [LEN-1:0]           mid_vld;
  logic [LEN-1:0][DW-1:0]   nxt_data;
  logic [LEN-1:0]           nxt_vld;
  logic                     advance;

  belt_pack #(.NDROP(NDROP), .DW(DW), .DCW(DCW)) u_pack (
    .vld(drop_vld), .data(drop_data), .packed_q(packed_drops), .cnt(drop_cnt)
  );

  belt_rescue #(.LEN(LEN), .DW(DW), .NRESC(NRESC), .AW(AW), .CW(CW)) u_rescue (
    .cur_data(slot_q), .cur_vld(vld_q), .en(resc_en), .cnt(resc_cnt),
    .pos(resc_pos), .mid_data(mid_data), .mid_vld(mid_vld)
  );

  belt_read #(.LEN(LEN), .DW(DW), .NRD(NRD), .AW(AW)) u_read (
    .slot_data(slot_q), .slot_vld(vld_q), .off(rd_off), .data(rd_data), .vld(rd_vld)
  );

  assign advance = (drop_cnt != '0) || resc_en;

  // packed drops go in front of the (possibly reordered) belt
  always_comb begin
    int n;
    int k;
    n = int'(drop_cnt);
    for (int j = 0; j < LEN; j++) begin
      k = (j < NDROP) ? j : 0;
      if (j < n) begin
        nxt_data[j] = packed_drops[k];
        nxt_vld[j]  = 1'b1;
      end else begin
        nxt_data[j] = mid_data[shifted_src(j, n)];
        nxt_vld[j]  = mid_vld[shifted_src(j, n)];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= '0;
      vld_q  <= '0;
    end else if (advance) begin
      slot_q <= nxt_data;
      vld_q  <= nxt_vld;
    end
  end

  // R2: idle cycle leaves the belt alone
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_vld == '0 && !resc_en) |=> ($stable(slot_q) && $stable(vld_q)));

  // R3: any drop fills the front position
  p_front_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_vld != '0 && !resc_en) |=> vld_q[0]);

  // R3: a single drop shifts every older entry back by one
  p_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(drop_vld) == 1 && !resc_en) |=>
      (slot_q[LEN-1:1] == $past(slot_q[LEN-2:0])));

  // R4: port 0 always lands at the front when valid
  p_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_vld[0] && !resc_en) |=> (slot_q[0] == $past(drop_data[DW-1:0])));

  // R5: without a rescue the number of live slots never shrinks
  p_no_shrink_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !resc_en |=> ($countones(vld_q) >= $past($countones(vld_q))));

  // R8: first listed operand reaches the front
  p_rescue_head_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (resc_en && resc_cnt != '0 && drop_vld == '0) |=>
      (slot_q[0] == $past(slot_q[resc_pos[AW-1:0]])));
endmodule

// File: tb/tb_belt_store.sv
module tb_belt_store;
  localparam int CLK_PERIOD = 10;
  localparam int LEN   = 8;
  localparam int DW    = 16;
  localparam int NDROP = 4;
  localparam int NRD   = 4;
  localparam int NRESC = 3;
  localparam int AW    = $clog2(LEN);
  localparam int CW    = $clog2(NRESC + 1);

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [NDROP-1:0]    drop_vld = '0;
  logic [NDROP*DW-1:0] drop_data = '0;
  logic                resc_en = 1'b0;
  logic [CW-1:0]       resc_cnt = '0;
  logic [NRESC*AW-1:0] resc_pos = '0;
  logic [NRD*AW-1:0]   rd_off = '0;
  logic [NRD*DW-1:0]   rd_data;
  logic [NRD-1:0]      rd_vld;

  belt_store #(.LEN(LEN), .DW(DW), .NDROP(NDROP), .NRD(NRD), .NRESC(NRESC)) dut (
    .clk(clk), .rst_n(rst_n), .drop_vld(drop_vld), .drop_data(drop_data),
    .resc_en(resc_en), .resc_cnt(resc_cnt), .resc_pos(resc_pos),
    .rd_off(rd_off), .rd_data(rd_data), .rd_vld(rd_vld)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [DW-1:0] m  [LEN];
  bit            mv [LEN];
  int seq = 1;

  task automatic cmp(input string req, input int off, input logic [DW-1:0] got,
                     input logic [DW-1:0] exp, input bit gv, input bit ev);
    checks++;
    if (got !== exp || gv !== ev) begin
      fails++;
      $display("FAIL %s off=%0d actual=%h/%0b expected=%h/%0b", req, off, got, gv, exp, ev);
    end
  endtask

  // read every position through the ports and compare with the model
  task automatic check_all(input string req);
    for (int base = 0; base < LEN; base += NRD) begin
      for (int p = 0; p < NRD; p++) rd_off[p*AW +: AW] = AW'((base + p) % LEN);
      #1;
      for (int p = 0; p < NRD; p++) begin
        int o;
        o = (base + p) % LEN;
        cmp(req, o, rd_data[p*DW +: DW], mv[o] ? m[o] : '0, rd_vld[p], mv[o]);
      end
    end
  endtask

  // one belt step: apply drops and an optional rescue, update the model as a queue
  task automatic step(input string req, input logic [NDROP-1:0] dv, input bit ren,
                      input int rc, input int rp [NRESC]);
    logic [DW-1:0] tq [$];
    bit            tv [$];
    logic [DW-1:0] nd [LEN];
    bit            nv [LEN];
    logic [DW-1:0] vals [NDROP];
    bit listed;
    int c;
    int n;
    @(negedge clk);
    for (int i = 0; i < NDROP; i++) begin
      vals[i] = DW'(seq * 37 + i);
      drop_data[i*DW +: DW] = vals[i];
    end
    seq++;
    drop_vld = dv;
    resc_en  = ren;
    resc_cnt = CW'(rc);
    for (int j = 0; j < NRESC; j++) resc_pos[j*AW +: AW] = AW'(rp[j]);
    // R6: before the edge, offset 0 still shows the stored front
    rd_off = '0;
    #1;
    cmp({req, "/R6"}, 0, rd_data[DW-1:0], mv[0] ? m[0] : '0, rd_vld[0], mv[0]);
    // model: rescue first (queue of named then remaining), then drops in front
    c = (rc > NRESC) ? NRESC : rc;
    if (ren) begin
      for (int j = 0; j < c; j++) begin tq.push_back(m[rp[j]]); tv.push_back(mv[rp[j]]); end
      for (int i = 0; i < LEN; i++) begin
        listed = 0;
        for (int j = 0; j < c; j++) if (rp[j] == i) listed = 1;
        if (!listed) begin tq.push_back(m[i]); tv.push_back(mv[i]); end
      end
    end else begin
      for (int i = 0; i < LEN; i++) begin tq.push_back(m[i]); tv.push_back(mv[i]); end
    end
    n = 0;
    for (int i = NDROP - 1; i >= 0; i--) begin
      if (dv[i]) begin tq.push_front(vals[i]); tv.push_front(1'b1); n++; end
    end
    for (int i = 0; i < LEN; i++) begin nd[i] = tq[i]; nv[i] = tv[i]; end
    @(posedge clk);
    #1;
    drop_vld = '0;
    resc_en  = 1'b0;
    for (int i = 0; i < LEN; i++) begin m[i] = nd[i]; mv[i] = nv[i]; end
    check_all(req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int none [NRESC];
    int rp   [NRESC];
    for (int j = 0; j < NRESC; j++) none[j] = 0;
    for (int i = 0; i < LEN; i++) begin m[i] = '0; mv[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check_all("R1 reset empty");
    step("R2 idle empty", 4'b0000, 0, 0, none);
    step("R7 partial fill", 4'b0001, 0, 0, none);
    // R3 R4 R5: all drop patterns, several passes, overflowing the belt
    for (int pass = 0; pass < 3; pass++) begin
      for (int pat = 0; pat < 16; pat++) step("R3/R4/R5 drops", NDROP'(pat), 0, 0, none);
    end
    step("R2 idle full", 4'b0000, 0, 0, none);
    // R11: every port on the same offset
    for (int o = 0; o < LEN; o++) begin
      rd_off = {NRD{AW'(o)}};
      #1;
      for (int p = 0; p < NRD; p++) cmp("R11 same offset", o, rd_data[p*DW +: DW], m[o], rd_vld[p], mv[o]);
    end
    // R10: zero-length rescue
    step("R10 empty rescue", 4'b0000, 1, 0, none);
    // R8 alone, R9 combined with drops
    for (int it = 0; it < 120; it++) begin
      bit used [LEN];
      int c;
      int p;
      for (int i = 0; i < LEN; i++) used[i] = 0;
      for (int j = 0; j < NRESC; j++) begin
        do p = int'($urandom % LEN); while (used[p]);
        used[p] = 1;
        rp[j] = p;
      end
      c = 1 + (it % NRESC);
      if (it % 2 == 0) step("R8 rescue", 4'b0000, 1, c, rp);
      else step("R9 rescue+drops", NDROP'(it % 16), 1, c, rp);
    end
    // R7: fresh reset, partial fill leaves empty tail
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    for (int i = 0; i < LEN; i++) begin m[i] = '0; mv[i] = 0; end
    check_all("R1 second reset");
    step("R7 empty tail", 4'b1010, 0, 0, none);
    rp[0] = 5; rp[1] = 0; rp[2] = 7;
    step("R8 rescue of empty slot", 4'b0000, 1, 3, rp);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule